// File: doc/BRIEF.md
# Status/Control Register with Refresh-on-Write Watchdog

This block is one byte-wide register with two jobs. The first is status and control. Reads return live monitor bits from an outside bus engine: a completion flag that is low while an access is still outstanding, and the current levels of the address strobe and the two data strobes. Two writable control bits set how the watchdog behaves. The second job is the watchdog itself. Every write to the register restarts its count, whatever data is written, so software refreshes the watchdog simply by writing its control settings again.

One control bit picks a long or a short timeout. Both periods are tick-count parameters, so a real clock rate can map them to about 8 s and about 250 ms while simulation uses small values. A second control bit picks what happens at expiry. With the bit clear, a sticky interrupt is raised and held until the next write. With the bit set, a one-cycle reset request pulse is raised instead. The bus protocol engine and the distribution of the system reset are outside this block.

Top module: `wdog_ctl_stat`

## Requirements
- R1: While rst_n is low, irq and rst_req are 0 and both control bits are 0. The internal reset is released on the second rising clock edge after rst_n rises. The watchdog starts counting from the edge after that.
- R2: A write (wr_en high at a rising edge) restarts the watchdog count from zero and clears irq, whatever the value of wr_data. A write at the same edge as a due expiry wins over the expiry.
- R3: With the fast bit (bit 4) at 0 and no write, expiry takes effect at the LONG_TICKS-th rising edge after the last write edge, or after the previous expiry.
- R4: With the fast bit at 1 and no write, expiry takes effect at the SHORT_TICKS-th rising edge after the last write edge, or after the previous expiry.
- R5: If the reset-enable bit (bit 5) is 0 at expiry, irq goes to 1 and stays at 1 until the next write.
- R6: If the reset-enable bit is 1 at expiry, rst_req is 1 for exactly one cycle and irq is not changed. This repeats every period while no write occurs.
- R7: Read bit 0 (completion) reads the inverse of bus_busy, live and without delay.
- R8: Read bits 1, 2 and 3 read bus_as, bus_ds0 and bus_ds1, live and without delay.
- R9: Bits 0 to 3 ignore write data. Bits 7 and 6 always read 0. Bits 4 and 5 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data: status bits and control bits |
| bus_busy | input | 1 | High while a bus access is outstanding |
| bus_as | input | 1 | Address strobe level |
| bus_ds0 | input | 1 | Data strobe 0 level |
| bus_ds1 | input | 1 | Data strobe 1 level |
| irq | output | 1 | Sticky watchdog interrupt |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
A wrong count or a missed restart shows at the ports as an irq rise or an rst_req pulse that comes one or more cycles away from the edge the requirements predict. It is seen within one timeout period of the fault. A wrong control bit shows on the next read of bits 4 and 5, and it also shows as the wrong period or the wrong expiry action at the next expiry. A fault in the status path shows on rd_data in the same cycle that the monitor inputs change. The bench therefore compares every cycle against a behavioural model, and it also checks the expected expiry edges directly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W    = 8;
  // read/write bit positions of the register
  localparam int B_DONE   = 0;
  localparam int B_AS     = 1;
  localparam int B_DS0    = 2;
  localparam int B_DS1    = 3;
  localparam int B_FAST   = 4;
  localparam int B_RSTEN  = 5;

  typedef struct packed {
    logic fast;
    logic rst_en;
  } wdt_ctl_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_int_n = s2_q;
endmodule

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             bus_busy,
  input  logic             bus_as,
  input  logic             bus_ds0,
  input  logic             bus_ds1,
  output wdt_ctl_t         ctl,
  output logic [REG_W-1:0] rd_data
);
  wdt_ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.fast   = wr_data[B_FAST];
      ctl_d.rst_en = wr_data[B_RSTEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[B_DONE]  = ~bus_busy;
    rd_data[B_AS]    = bus_as;
    rd_data[B_DS0]   = bus_ds0;
    rd_data[B_DS1]   = bus_ds1;
    rd_data[B_FAST]  = ctl_q.fast;
    rd_data[B_RSTEN] = ctl_q.rst_en;
  end

  assign ctl = ctl_q;

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q)) else $error("ctl changed without write"); // R9
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctl_q.fast == $past(wr_data[B_FAST])) else $error("fast bit not loaded"); // R9
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int LONG_TICKS  = 1_000_000_000,
  parameter int SHORT_TICKS = 31_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic fast,
  input  logic rst_en,
  output logic irq,
  output logic rst_req
);
  localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim_m1;
  logic          irq_q, irq_d, rrq_q, rrq_d;
  logic          expire;

  assign lim_m1 = fast ? SHORT_M1 : LONG_M1;
  assign expire = !kick && (cnt_q >= lim_m1);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    irq_d = irq_q;
    rrq_d = 1'b0;
    if (kick) begin
      cnt_d = '0;
      irq_d = 1'b0;
    end else if (expire) begin
      cnt_d = '0;
      if (rst_en) rrq_d = 1'b1;
      else        irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      rrq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      rrq_q <= rrq_d;
    end
  end

  assign irq     = irq_q;
  assign rst_req = rrq_q;

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !irq_q && cnt_q == '0) else $error("write did not restart"); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_m1) else $error("count past limit"); // R3
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !kick |=> irq_q) else $error("irq dropped without write"); // R5
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rrq_q |=> !rrq_q) else $error("reset request longer than one cycle"); // R6
  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rrq_q |-> rst_en) else $error("reset request while disabled"); // R6
  AST_IRQ_RISE_NOEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> !rst_en && !rrq_q) else $error("irq rose while reset mode"); // R5
endmodule

// File: rtl/wdog_ctl_stat.sv
module wdog_ctl_stat
  import wdt_pkg::*;
#(
  parameter int LONG_TICKS  = 1_000_000_000,
  parameter int SHORT_TICKS = 31_250_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             bus_busy,
  input  logic             bus_as,
  input  logic             bus_ds0,
  input  logic             bus_ds1,
  output logic             irq,
  output logic             rst_req
);
  logic     rst_int_n;
  logic     wr_ok;
  wdt_ctl_t ctl;

  wdt_rst_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  assign wr_ok = wr_en & rst_int_n;

  wdt_ctl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_ok),
    .wr_data  (wr_data),
    .bus_busy (bus_busy),
    .bus_as   (bus_as),
    .bus_ds0  (bus_ds0),
    .bus_ds1  (bus_ds1),
    .ctl      (ctl),
    .rd_data  (rd_data)
  );

  wdt_timer #(
    .LONG_TICKS  (LONG_TICKS),
    .SHORT_TICKS (SHORT_TICKS)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .kick    (wr_ok),
    .fast    (ctl.fast),
    .rst_en  (ctl.rst_en),
    .irq     (irq),
    .rst_req (rst_req)
  );

  AST_DONE_LIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_data[B_DONE] != bus_busy) else $error("completion bit wrong"); // R7
  AST_STROBE_LIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_data[B_DS1:B_AS] == {bus_ds1, bus_ds0, bus_as}) else $error("strobe bits wrong"); // R8
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_data[REG_W-1:B_RSTEN+1] == '0) else $error("reserved bits nonzero"); // R9
  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(irq) |-> !rst_req) else $error("irq and reset together"); // R6
endmodule

// File: tb/wdog_ctl_stat_bench.sv
`timescale 1ns/1ps
module wdog_ctl_stat_bench;
  localparam int LT = 40;
  localparam int ST = 12;

  logic       clk, rst_n, wr_en, bus_busy, bus_as, bus_ds0, bus_ds1;
  logic [7:0] wr_data, rd_data;
  logic       irq, rst_req;

  int n_tests, n_fail, cyc;

  // behavioural reference state
  int m_cnt, m_sync;
  bit m_irq, m_rst, m_fast, m_ren;

  wdog_ctl_stat #(.LONG_TICKS(LT), .SHORT_TICKS(ST)) u_wdog_ctl_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .bus_busy(bus_busy), .bus_as(bus_as), .bus_ds0(bus_ds0), .bus_ds1(bus_ds1),
    .irq(irq), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sync = 0; m_irq = 0; m_rst = 0; m_fast = 0; m_ren = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      int lim;
      lim = m_fast ? ST : LT;
      m_rst = 0;
      if (wr_en) begin
        m_cnt = 0; m_irq = 0; m_fast = wr_data[4]; m_ren = wr_data[5];
      end else if (m_cnt == lim - 1) begin
        m_cnt = 0;
        if (m_ren) m_rst = 1; else m_irq = 1;
      end else begin
        m_cnt++;
      end
    end
  end

  // per-cycle comparison, away from the clock edge
  always begin
    @(negedge clk); #2;
    cyc++;
    if (!rst_n) begin
      check(irq == 0 && rst_req == 0, "R1", {irq, rst_req}, 0);
      check(rd_data[5:4] == 0, "R1", rd_data[5:4], 0);
    end else begin
      check(irq == m_irq, "R5", irq, m_irq);
      check(rst_req == m_rst, "R6", rst_req, m_rst);
      check(rd_data[0] == !bus_busy, "R7", rd_data[0], !bus_busy);
      check(rd_data[3:1] == {bus_ds1, bus_ds0, bus_as}, "R8", rd_data[3:1],
            {bus_ds1, bus_ds0, bus_as});
      check(rd_data[7:4] == {2'b00, m_ren, m_fast}, "R9", rd_data[7:4],
            {2'b00, m_ren, m_fast});
    end
  end

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0;
    rst_n = 0; wr_en = 0; wr_data = 0;
    bus_busy = 1; bus_as = 0; bus_ds0 = 0; bus_ds1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: first expiry after release at sync(2) + LT edges
    wait_edges(2 + LT - 1);
    check(irq == 0, "R1", irq, 0);
    wait_edges(1);
    check(irq == 1, "R3", irq, 1);
    // R5: irq sticky over a further period
    wait_edges(LT + 3);
    check(irq == 1, "R5", irq, 1);
    // R7/R8 live status patterns
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      {bus_ds1, bus_ds0, bus_as, bus_busy} = 4'(p);
    end
    // R2/R9: write all ones, RO bits ignore data, fast+rst_en set
    do_write(8'hFF);
    #1;
    check(irq == 0, "R2", irq, 0);
    check(rd_data[7:6] == 2'b00 && rd_data[5:4] == 2'b11, "R9", rd_data[7:4], 4'h3);
    // R6: short period with reset pulses
    wait_edges(ST - 1);
    check(rst_req == 0, "R6", rst_req, 0);
    wait_edges(1);
    check(rst_req == 1, "R6", rst_req, 1);
    wait_edges(1);
    check(rst_req == 0, "R6", rst_req, 0);
    wait_edges(ST - 1);
    check(rst_req == 1, "R6", rst_req, 1);
    // R4: fast, irq mode
    do_write(8'h10);
    wait_edges(ST - 1);
    check(irq == 0, "R4", irq, 0);
    wait_edges(1);
    check(irq == 1, "R4", irq, 1);
    // R2: periodic writes keep it quiet, data varies
    do_write(8'h00);
    for (int k = 0; k < 6; k++) begin
      wait_edges(LT - 5);
      check(irq == 0, "R2", irq, 0);
      do_write(8'(k * 8'h4B) & 8'hCF);
    end
    // R3: long period timing after a write
    do_write(8'h00);
    wait_edges(LT - 1);
    check(irq == 0, "R3", irq, 0);
    wait_edges(1);
    check(irq == 1, "R3", irq, 1);
    // R2: write coinciding with a due expiry wins
    do_write(8'h10);
    wait_edges(ST - 2);
    @(negedge clk); wr_en = 1; wr_data = 8'h10;
    @(negedge clk); wr_en = 0; #1;
    check(irq == 0, "R2", irq, 0);
    wait_edges(ST - 1);
    check(irq == 0, "R2", irq, 0);
    wait_edges(1);
    check(irq == 1, "R4", irq, 1);
    // R1: reset mid-run clears control and outputs
    @(negedge clk); rst_n = 0; #1;
    check(irq == 0 && rd_data[5:4] == 0, "R1", {irq, rd_data[5:4]}, 0);
    @(negedge clk); rst_n = 1;
    wait_edges(2 + LT);
    check(irq == 1, "R1", irq, 1);
    wait_edges(4);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run hung (R1) actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule